// File: doc/BRIEF.md
# CPU Frequency Target Selector with Glitch-Free Ramp

This block works out the CPU clock target that a clock synthesizer should aim for. A 5-bit table index chooses one of 32 built-in CPU/PCI frequency pairs. The upper index bit always comes from a control register. The lower four bits come from board strap pins or from the register, depending on a source-select control. A signed fine-tune offset is then added in steps of 0.22 MHz. All frequencies are integers in units of 10 kHz.

The block also decides the spread-spectrum mode and computes a PCI target that scales with the CPU target. It does this with a sequential divider, rounding the result to the nearest unit.

When the target changes, the delivered CPU value does not jump. It walks toward the new target in bounded steps, with one step per tick of a programmable timer, so the synthesizer downstream never sees a large jump. At reset the delivered value loads the target directly.

Top module: `freq_target_sel`

## Requirements
- R1: When `use_reg_sel_i` is 1, index bits 3..0 come from `reg_fs_i`; when it is 0 they come from `strap_fs_i`, and `reg_fs_i` has no effect. Index bit 4 is always `reg_fs_hi_i`.
- R2: The table value for the index is used as the base. Examples in 10 kHz units: index 0 = 12400, 3 = 6680, 4 = 10300, 7 = 10000, 13 = 15000, 22 = 13650, 23 = 10000, 24 = 12000, 31 = 13330.
- R3: `offset_i` is sign-magnitude. Bit 7 set means negative and bits 6..0 are the magnitude, so a value of 0x80 acts as zero. `cpu_target_o` = base + 22 × signed offset.
- R4: `spread_on_o` equals `spread_en_i`. `spread_down_o` is 1 only when spread is on and the index is 23, 24 or 31; all other indices use centre spread.
- R5: `pci_target_o` = floor((pci_base × cpu_target + floor(cpu_base / 2)) / cpu_base). `pci_valid_o` is 0 while that result is being recomputed.
- R6: Each change of `cpu_freq_o` moves it toward `cpu_target_o` by at most 22 units, and it never passes the target. The last step may be shorter than 22.
- R7: With ramp period P, a ramp step happens only on a timer tick. A change registered at clock edge 1 produces step k at edge 1 + (P+1)·k.
- R8: `ramp_done_o` is 1 exactly when `cpu_freq_o` equals `cpu_target_o`.
- R9: While `rst` is high, `cpu_freq_o` and `cpu_target_o` load the target of the current inputs. On the first cycle after reset, `ramp_done_o` is 1 and `pci_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_fs_i | input | 4 | Board strap index bits 3..0 |
| use_reg_sel_i | input | 1 | 1 = register supplies index bits 3..0 |
| reg_fs_i | input | 4 | Register index bits 3..0 |
| reg_fs_hi_i | input | 1 | Index bit 4 |
| spread_en_i | input | 1 | Spread-spectrum enable |
| offset_i | input | 8 | Sign-magnitude fine-tune offset |
| ramp_period_i | input | 16 | Ramp tick period minus one, in cycles |
| cpu_freq_o | output | 16 | Delivered (ramped) CPU value, 10 kHz units |
| cpu_target_o | output | 16 | CPU target, 10 kHz units |
| pci_target_o | output | 16 | Scaled PCI target, 10 kHz units |
| pci_valid_o | output | 1 | PCI target is current |
| ramp_done_o | output | 1 | Delivered value equals target |
| spread_on_o | output | 1 | Spread active |
| spread_down_o | output | 1 | Downspread (else centre spread) |

## Verification
The selection path is tried with several input patterns:
- Register-sourced indices, with the strap pins holding different values, show that the source select works.
- Strap-sourced indices, with the register bits held at conflicting values, show that those register bits are ignored.
- The offset patterns are positive, negative, the full magnitude of 127 in both directions, and negative zero. Together they separate correct sign handling from a plain two's-complement reading.
- The chosen indices give one exactly divisible PCI ratio, one that rounds down and one that rounds up, so truncation in the divider is caught.
- Both downspread and centre-spread indices appear with spread on and with spread off.

The ramp is timed with a nonzero period, with a step count that is a whole multiple of 22 and with one that ends in a short final step.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int IDX_W = 5;

  // CPU base frequency per index, 10 kHz units
  function automatic logic [15:0] cpu_base(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:  cpu_base = 16'd12400;  5'd1:  cpu_base = 16'd7500;
      5'd2:  cpu_base = 16'd8330;   5'd3:  cpu_base = 16'd6680;
      5'd4:  cpu_base = 16'd10300;  5'd5:  cpu_base = 16'd11200;
      5'd6:  cpu_base = 16'd13330;  5'd7:  cpu_base = 16'd10000;
      5'd8:  cpu_base = 16'd12000;  5'd9:  cpu_base = 16'd11500;
      5'd10: cpu_base = 16'd11000;  5'd11: cpu_base = 16'd10500;
      5'd12: cpu_base = 16'd14000;  5'd13: cpu_base = 16'd15000;
      5'd14: cpu_base = 16'd12400;  5'd15: cpu_base = 16'd13330;
      5'd16: cpu_base = 16'd9000;   5'd17: cpu_base = 16'd9250;
      5'd18: cpu_base = 16'd9500;   5'd19: cpu_base = 16'd9750;
      5'd20: cpu_base = 16'd10150;  5'd21: cpu_base = 16'd12700;
      5'd22: cpu_base = 16'd13650;  5'd23: cpu_base = 16'd10000;
      5'd24: cpu_base = 16'd12000;  5'd25: cpu_base = 16'd11750;
      5'd26: cpu_base = 16'd12200;  5'd27: cpu_base = 16'd10750;
      5'd28: cpu_base = 16'd14500;  5'd29: cpu_base = 16'd15500;
      5'd30: cpu_base = 16'd13000;  default: cpu_base = 16'd13330;
    endcase
  endfunction

  // PCI base frequency per index, 10 kHz units
  function automatic logic [15:0] pci_base(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:  pci_base = 16'd4130;  5'd1:  pci_base = 16'd3750;
      5'd2:  pci_base = 16'd4170;  5'd3:  pci_base = 16'd3340;
      5'd4:  pci_base = 16'd3430;  5'd5:  pci_base = 16'd3730;
      5'd6:  pci_base = 16'd4440;  5'd7:  pci_base = 16'd3330;
      5'd8:  pci_base = 16'd4000;  5'd9:  pci_base = 16'd3830;
      5'd10: pci_base = 16'd3670;  5'd11: pci_base = 16'd3500;
      5'd12: pci_base = 16'd3500;  5'd13: pci_base = 16'd3750;
      5'd14: pci_base = 16'd3100;  5'd15: pci_base = 16'd3330;
      5'd16: pci_base = 16'd3000;  5'd17: pci_base = 16'd3080;
      5'd18: pci_base = 16'd3170;  5'd19: pci_base = 16'd3250;
      5'd20: pci_base = 16'd3380;  5'd21: pci_base = 16'd4230;
      5'd22: pci_base = 16'd3410;  5'd23: pci_base = 16'd3330;
      5'd24: pci_base = 16'd4000;  5'd25: pci_base = 16'd3920;
      5'd26: pci_base = 16'd4070;  5'd27: pci_base = 16'd3580;
      5'd28: pci_base = 16'd3630;  5'd29: pci_base = 16'd3870;
      5'd30: pci_base = 16'd3250;  default: pci_base = 16'd3330;
    endcase
  endfunction

  function automatic logic uses_downspread(input logic [IDX_W-1:0] i);
    uses_downspread = (i == 5'd23) || (i == 5'd24) || (i == 5'd31);
  endfunction
endpackage

// File: rtl/fsel_lookup.sv
module fsel_lookup
  import fsel_pkg::*;
#(
  parameter int FW   = 16,
  parameter int OW   = 8,
  parameter int STEP = 22
) (
  input  logic [3:0]          strap_fs_i,
  input  logic                use_reg_sel_i,
  input  logic [3:0]          reg_fs_i,
  input  logic                reg_fs_hi_i,
  input  logic [OW-1:0]       offset_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic [FW-1:0]       cpu_base_o,
  output logic [FW-1:0]       pci_base_o,
  output logic [FW-1:0]       target_o
);
  localparam int PW = FW + 2;

  logic [PW-1:0] prod;
  logic [PW-1:0] sum;

  always_comb begin
    idx_o      = {reg_fs_hi_i, (use_reg_sel_i ? reg_fs_i : strap_fs_i)};
    cpu_base_o = FW'(cpu_base(idx_o));
    pci_base_o = FW'(pci_base(idx_o));
    prod       = PW'(offset_i[OW-2:0]) * PW'(STEP);
    sum        = offset_i[OW-1] ? (PW'(cpu_base_o) - prod) : (PW'(cpu_base_o) + prod);
    target_o   = sum[FW-1:0];
  end
endmodule

// File: rtl/fsel_ramp.sv
module fsel_ramp #(
  parameter int FW   = 16,
  parameter int TW   = 16,
  parameter int STEP = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] init_i,
  input  logic [FW-1:0] tgt_i,
  input  logic [TW-1:0] period_i,
  output logic [FW-1:0] cur_o
);
  logic [FW-1:0] cur_q, nxt, diff;
  logic [TW-1:0] cnt_q;
  logic          tick;

  assign tick  = (cnt_q >= period_i);
  assign cur_o = cur_q;

  always_comb begin
    if (tgt_i > cur_q) begin
      diff = tgt_i - cur_q;
      nxt  = (diff > FW'(STEP)) ? cur_q + FW'(STEP) : tgt_i;
    end else begin
      diff = cur_q - tgt_i;
      nxt  = (diff > FW'(STEP)) ? cur_q - FW'(STEP) : tgt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= init_i;
      cnt_q <= '0;
    end else if (cur_q == tgt_i) begin
      cnt_q <= '0;
    end else if (tick) begin
      cur_q <= nxt;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_step_up_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur_q > $past(cur_q)) |-> (cur_q - $past(cur_q) <= FW'(STEP)));
  assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur_q < $past(cur_q)) |-> ($past(cur_q) - cur_q <= FW'(STEP)));
  assert_no_overshoot_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cur_q) <= $past(tgt_i)) |-> (cur_q <= $past(tgt_i)));
  assert_move_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur_q != $past(cur_q)) |-> $past(tick));
endmodule

// File: rtl/fsel_pci_scale.sv
module fsel_pci_scale #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] tgt_i,
  input  logic [FW-1:0] cpu_base_i,
  input  logic [FW-1:0] pci_base_i,
  output logic [FW-1:0] pci_o,
  output logic          valid_o
);
  localparam int NUMW = 2 * FW;
  localparam int KW   = 3 * FW;
  localparam int CW   = $clog2(NUMW);

  logic [KW-1:0]   key, key_q;
  logic            chg, busy_q, pend_q, valid_q, bit_n;
  logic [FW:0]     rem_q, trial, rem_n;
  logic [NUMW-1:0] quo_q, quo_n;
  logic [FW-1:0]   den_q, pci_q;
  logic [CW-1:0]   cnt_q;

  assign key     = {tgt_i, cpu_base_i, pci_base_i};
  assign chg     = (key != key_q);
  assign pci_o   = pci_q;
  assign valid_o = valid_q;

  always_comb begin
    trial = {rem_q[FW-1:0], quo_q[NUMW-1]};
    bit_n = (trial >= {1'b0, den_q});
    rem_n = bit_n ? (trial - {1'b0, den_q}) : trial;
    quo_n = {quo_q[NUMW-2:0], bit_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q   <= key;
      busy_q  <= 1'b0;
      pend_q  <= 1'b1;
      valid_q <= 1'b0;
      pci_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
    end else begin
      key_q <= key;
      if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q + 1'b1;
        if (chg) pend_q <= 1'b1;
        if (cnt_q == CW'(NUMW - 1)) begin
          busy_q  <= 1'b0;
          pci_q   <= quo_n[FW-1:0];
          valid_q <= !pend_q && !chg;
        end
      end else if (pend_q || chg) begin
        rem_q   <= '0;
        quo_q   <= NUMW'(pci_base_i) * NUMW'(tgt_i) + NUMW'(cpu_base_i >> 1);
        den_q   <= cpu_base_i;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        pend_q  <= 1'b0;
        valid_q <= 1'b0;
      end
    end
  end

  assert_busy_not_valid_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !valid_q);
  assert_change_drops_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(chg)) |-> !valid_q);
endmodule

// File: rtl/freq_target_sel.sv
module freq_target_sel
  import fsel_pkg::*;
#(
  parameter int FW   = 16,
  parameter int TW   = 16,
  parameter int OW   = 8,
  parameter int STEP = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    strap_fs_i,
  input  logic          use_reg_sel_i,
  input  logic [3:0]    reg_fs_i,
  input  logic          reg_fs_hi_i,
  input  logic          spread_en_i,
  input  logic [OW-1:0] offset_i,
  input  logic [TW-1:0] ramp_period_i,
  output logic [FW-1:0] cpu_freq_o,
  output logic [FW-1:0] cpu_target_o,
  output logic [FW-1:0] pci_target_o,
  output logic          pci_valid_o,
  output logic          ramp_done_o,
  output logic          spread_on_o,
  output logic          spread_down_o
);
  logic [IDX_W-1:0] idx_c;
  logic [FW-1:0]    cpu_base_c, pci_base_c, tgt_c;
  logic [FW-1:0]    tgt_q, cpu_base_q, pci_base_q, cur;
  logic             spread_on_q, spread_down_q;

  fsel_lookup #(.FW(FW), .OW(OW), .STEP(STEP)) u_lookup (
    .strap_fs_i, .use_reg_sel_i, .reg_fs_i, .reg_fs_hi_i, .offset_i,
    .idx_o(idx_c), .cpu_base_o(cpu_base_c), .pci_base_o(pci_base_c), .target_o(tgt_c)
  );

  always_ff @(posedge clk) begin
    tgt_q         <= tgt_c;
    cpu_base_q    <= cpu_base_c;
    pci_base_q    <= pci_base_c;
    spread_on_q   <= spread_en_i;
    spread_down_q <= spread_en_i && uses_downspread(idx_c);
  end

  fsel_ramp #(.FW(FW), .TW(TW), .STEP(STEP)) u_ramp (
    .clk, .rst, .init_i(tgt_c), .tgt_i(tgt_q), .period_i(ramp_period_i), .cur_o(cur)
  );

  fsel_pci_scale #(.FW(FW)) u_pci (
    .clk, .rst, .tgt_i(tgt_q), .cpu_base_i(cpu_base_q), .pci_base_i(pci_base_q),
    .pci_o(pci_target_o), .valid_o(pci_valid_o)
  );

  assign cpu_freq_o    = cur;
  assign cpu_target_o  = tgt_q;
  assign ramp_done_o   = (cur == tgt_q);
  assign spread_on_o   = spread_on_q;
  assign spread_down_o = spread_down_q;

  assert_down_needs_on_R4: assert property (@(posedge clk) disable iff (rst)
    spread_down_o |-> spread_on_o);
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ramp_done_o) && $stable(cpu_target_o)) |-> ramp_done_o);
endmodule

// File: tb/freq_target_sel_bench.sv
module freq_target_sel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  strap_fs = 4'b0111, reg_fs = 4'b0000;
  logic        use_reg = 1'b0, fs_hi = 1'b0, sp_en = 1'b0;
  logic [7:0]  offset = 8'h00;
  logic [15:0] period = 16'd0;
  logic [15:0] cpu_freq, cpu_tgt, pci_tgt;
  logic        pci_valid, done, sp_on, sp_down;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  freq_target_sel u_freq_target_sel (
    .clk, .rst, .strap_fs_i(strap_fs), .use_reg_sel_i(use_reg), .reg_fs_i(reg_fs),
    .reg_fs_hi_i(fs_hi), .spread_en_i(sp_en), .offset_i(offset), .ramp_period_i(period),
    .cpu_freq_o(cpu_freq), .cpu_target_o(cpu_tgt), .pci_target_o(pci_tgt),
    .pci_valid_o(pci_valid), .ramp_done_o(done), .spread_on_o(sp_on), .spread_down_o(sp_down)
  );

  // use_reg, hi, reg_fs, strap, spread, offset, exp cpu, exp pci, exp on, exp down
  localparam logic [52:0] VEC [8] = '{
    {1'b1, 1'b1, 4'b0110, 4'b0000, 1'b0, 8'h0B, 16'd13892, 16'd3470, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'b0000, 4'b0111, 1'b0, 8'h00, 16'd10000, 16'd3330, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'b1111, 4'b0000, 1'b1, 8'h85, 16'd13220, 16'd3303, 1'b1, 1'b1},
    {1'b0, 1'b0, 4'b1111, 4'b0000, 1'b1, 8'h7F, 16'd15194, 16'd5061, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'b1010, 4'b0011, 1'b0, 8'hFF, 16'd3886,  16'd1943, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'b0000, 4'b1000, 1'b1, 8'h00, 16'd12000, 16'd4000, 1'b1, 1'b1},
    {1'b0, 1'b1, 4'b0000, 4'b0111, 1'b1, 8'h80, 16'd10000, 16'd3330, 1'b1, 1'b1},
    {1'b1, 1'b0, 4'b1101, 4'b0110, 1'b1, 8'h00, 16'd15000, 16'd3750, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    for (int n = 0; n < 2000 && !(done && pci_valid); n++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    // R9: reset loads target directly
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_freq == 16'd10000, "R9 cpu_freq after reset", cpu_freq, 10000);
    check(done == 1'b1, "R9 ramp_done after reset", done, 1);
    check(pci_valid == 1'b0, "R9 pci_valid after reset", pci_valid, 0);
    settle();
    check(pci_tgt == 16'd3330, "R5 pci after reset", pci_tgt, 3330);

    // Vector table: R1 source, R2 table, R3 offset, R4 spread, R5 pci
    for (int i = 0; i < 8; i++) begin
      logic [52:0] v;
      v = VEC[i];
      use_reg = v[52]; fs_hi = v[51]; reg_fs = v[50:47]; strap_fs = v[46:43];
      sp_en = v[42]; offset = v[41:34];
      settle();
      check(cpu_tgt == v[33:18], "R1 R2 R3 cpu target", cpu_tgt, v[33:18]);
      check(cpu_freq == v[33:18], "R6 ramp reaches target", cpu_freq, v[33:18]);
      check(done == 1'b1, "R8 done at target", done, 1);
      check(pci_tgt == v[17:2], "R5 pci target", pci_tgt, v[17:2]);
      check(sp_on == v[1], "R4 spread on", sp_on, v[1]);
      check(sp_down == v[0], "R4 downspread", sp_down, v[0]);
    end

    // R7: ramp timing with period 3, from idx7 (10000) to +11 steps
    use_reg = 1'b0; fs_hi = 1'b0; strap_fs = 4'b0111; sp_en = 1'b0; offset = 8'h00;
    settle();
    period = 16'd3;
    @(negedge clk);
    offset = 8'h0B;
    begin
      int n = 0;
      int max_step = 0;
      int prev = 10000;
      bit backwards = 0;
      do begin
        @(negedge clk);
        n++;
        if (int'(cpu_freq) - prev > max_step) max_step = int'(cpu_freq) - prev;
        if (int'(cpu_freq) < prev) backwards = 1;
        prev = int'(cpu_freq);
      end while (!(done && cpu_tgt == 16'd10242) && n < 500);
      check(n == 45, "R7 edges to finish ramp", n, 45);
      check(max_step <= 22, "R6 largest step", max_step, 22);
      check(!backwards, "R6 monotonic ramp", backwards, 0);
      check(cpu_freq == 16'd10242, "R6 final value", cpu_freq, 10242);
    end

    // R6/R8: partial final step, period 0, 10242 -> 10300 (idx4)
    period = 16'd0;
    @(negedge clk);
    strap_fs = 4'b0100; offset = 8'h00;
    @(negedge clk);
    @(negedge clk);
    check(cpu_freq == 16'd10264, "R6 first step", cpu_freq, 10264);
    check(done == 1'b0, "R8 done low mid-ramp", done, 0);
    @(negedge clk);
    check(cpu_freq == 16'd10286, "R6 second step", cpu_freq, 10286);
    @(negedge clk);
    check(cpu_freq == 16'd10300, "R6 short final step", cpu_freq, 10300);
    check(done == 1'b1, "R8 done at end", done, 1);

    // R1: register bits ignored when straps selected
    reg_fs = 4'b1101;
    repeat (3) @(negedge clk);
    check(cpu_tgt == 16'd10300, "R1 reg bits ignored", cpu_tgt, 10300);

    finish_run();
  end
endmodule